// File: doc/BRIEF.md
# Context-Decision Pair Sequencer

The sequencer sits between a column-parallel context modeler and a serial arithmetic coder. In one clock the modeler can produce anywhere from four to ten context/decision pairs for a stripe column. Each pair is a 5-bit context and a 1-bit decision. The coder takes exactly one pair per clock. The sequencer captures a whole column burst at once and then hands the pairs out one at a time, strictly in coding order, over a valid/ready handshake.

Every burst is presented as a fixed set of slots. Each slot has its own valid bit. Slot index equals coding position, and the sequencer always emits in ascending slot index. The producer uses this convention:

- slot 0 holds the run-length aggregation pair;
- slot 1 holds the run-length position pair;
- slot 2+2r holds the zero-coding or refinement pair of row r, with row 0 at the top;
- slot 3+2r holds the sign pair of that same row.

Empty slots are skipped without inserting an idle cycle. While a burst is draining, the sequencer holds its input ready low, so at most one burst is ever buffered. An end-of-block flag given with a burst comes out alongside the final pair of that burst.

Top module: `cxd_sequencer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `pair_valid` is 0 and `col_ready` is 1.
- R2: A burst is taken on a clock edge where `col_valid` and `col_ready` are both 1. Its valid slots are then emitted one per output handshake, in ascending slot index, each carrying the context from bits [5i+4:5i] of `col_ctx` and the decision from bit i of `col_dec`. No pair is emitted after the last valid slot.
- R3: Invalid slots produce no output cycle. While `pair_ready` is held at 1, the pairs of a burst appear in consecutive cycles with `pair_valid` continuously 1.
- R4: `col_ready` is 0 from the cycle after a burst with at least one valid slot is taken until the edge on which its last pair is handed over. It is 1 in the cycle after that edge.
- R5: While `pair_valid` is 1 and `pair_ready` is 0, `pair_valid`, `pair_ctx`, `pair_dec` and `pair_eob` keep their values on the next cycle.
- R6: `pair_eob` is 1 only together with the final valid pair of a burst taken with `col_eob` at 1. It is 0 for every other pair.
- R7: A burst with no valid slot is taken and dropped. No pair is emitted, and `col_ready` stays 1 in the following cycle.
- R8: The first pair of a non-empty burst is offered in the cycle right after the burst is taken.
- R9: While `col_ready` is 0, all `col_*` inputs are ignored. Changing them, or raising `col_valid`, does not alter the pairs being drained and adds no pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| col_valid | input | 1 | A column burst is presented |
| col_ready | output | 1 | Sequencer is empty and can take a burst |
| col_slot_vld | input | NSLOT | Per-slot valid bits of the burst |
| col_ctx | input | NSLOT*5 | Slot contexts, slot i in bits [5i+4:5i] |
| col_dec | input | NSLOT | Slot decisions, slot i in bit i |
| col_eob | input | 1 | Burst closes the code block |
| pair_valid | output | 1 | A pair is offered to the coder |
| pair_ready | input | 1 | Coder takes the offered pair |
| pair_ctx | output | 5 | Context of the offered pair |
| pair_dec | output | 1 | Decision of the offered pair |
| pair_eob | output | 1 | Offered pair is the last of the code block |

## Verification
The sequencer's state consists of a pending-slot mask, the captured pairs and one end-of-block flag. A mask bit that is not cleared shows up within a handful of cycles as a repeated pair or a `col_ready` that never returns. A bit that is lost or picked out of order shows up on the very next handshake as a wrong context or decision compared with the ascending-slot order. A stale or lost end-of-block flag is visible on the final pair of a burst, and a capture that is not gated by `col_ready` corrupts the pairs of the burst being drained right away. Bursts are therefore run with sparse and full masks, with stall patterns, with garbage on the input during the drain, and with empty bursts.

// File: rtl/cxd_seq_pkg.sv
package cxd_seq_pkg;

   // width of one context label handed to the arithmetic coder
   localparam int CXD_CTX_W = 5;

   typedef struct packed {
      logic [CXD_CTX_W-1:0] ctx;
      logic                 dec;
   } cxd_pair_t;

   // how the lowest pending slot is located
   typedef enum logic [0:0] {
      PICK_CHAIN = 1'b0,   // ripple of "seen below" terms, one OR per slot
      PICK_ARITH = 1'b1    // two's-complement isolate of the lowest set bit
   } pick_style_e;

endpackage

// File: rtl/cxd_slot_buf.sv
module cxd_slot_buf
   import cxd_seq_pkg::*;
#(
   parameter int NSLOT = 10
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load,
   input  logic [NSLOT-1:0]      load_mask,
   input  cxd_pair_t [NSLOT-1:0] load_pairs,
   input  logic                  load_eob,
   input  logic                  drop,
   input  logic [NSLOT-1:0]      drop_sel,
   output logic [NSLOT-1:0]      pend,
   output cxd_pair_t [NSLOT-1:0] pairs,
   output logic                  eob
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend <= '0;
         eob  <= 1'b0;
      end else if (load) begin
         pend <= load_mask;
         eob  <= load_eob;
      end else if (drop) begin
         pend <= pend & ~drop_sel;
      end
   end

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pairs[s] <= '0;
         end else if (load) begin
            pairs[s] <= load_pairs[s];
         end
      end
   end

   // R2
   pend_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ((pend & ~$past(pend)) == '0));

   // R2
   drop_hits_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drop |-> ((drop_sel & pend) != '0));

endmodule

// File: rtl/cxd_pick.sv
module cxd_pick
   import cxd_seq_pkg::*;
#(
   parameter int          NSLOT = 10,
   parameter pick_style_e STYLE = PICK_CHAIN,
   localparam int         IDX_W = $clog2(NSLOT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NSLOT-1:0] req,
   output logic [NSLOT-1:0] gnt,
   output logic [IDX_W-1:0] idx,
   output logic             any,
   output logic             final_one
);

   if (STYLE == PICK_CHAIN) begin : g_chain
      logic [NSLOT-1:0] seen;
      assign seen[0] = 1'b0;
      for (genvar i = 1; i < NSLOT; i++) begin : g_seen
         assign seen[i] = seen[i-1] | req[i-1];
      end
      assign gnt = req & ~seen;
   end else begin : g_arith
      localparam logic [NSLOT-1:0] ONE = {{(NSLOT-1){1'b0}}, 1'b1};
      assign gnt = req & (~req + ONE);
   end

   always_comb begin
      idx = '0;
      for (int i = 0; i < NSLOT; i++) begin
         if (gnt[i]) idx = idx | IDX_W'(i);
      end
   end

   assign any       = |req;
   assign final_one = any && ((req & ~gnt) == '0);

   // R2
   gnt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt) && ((gnt & ~req) == '0));

   // R3
   gnt_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req != '0) |-> (gnt != '0));

endmodule

// File: rtl/cxd_sequencer.sv
module cxd_sequencer
   import cxd_seq_pkg::*;
#(
   parameter int          NSLOT = 10,
   parameter pick_style_e PICK  = PICK_CHAIN,
   localparam int         CTX_W = CXD_CTX_W,
   localparam int         IDX_W = $clog2(NSLOT)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   col_valid,
   output logic                   col_ready,
   input  logic [NSLOT-1:0]       col_slot_vld,
   input  logic [NSLOT*CTX_W-1:0] col_ctx,
   input  logic [NSLOT-1:0]       col_dec,
   input  logic                   col_eob,
   output logic                   pair_valid,
   input  logic                   pair_ready,
   output logic [CTX_W-1:0]       pair_ctx,
   output logic                   pair_dec,
   output logic                   pair_eob
);

   if (NSLOT < 2 || NSLOT > 32) begin : g_bad_nslot
      $error("cxd_sequencer: NSLOT must lie in 2..32");
   end

   cxd_pair_t [NSLOT-1:0] in_pairs;
   cxd_pair_t [NSLOT-1:0] buf_pairs;
   logic [NSLOT-1:0]      pend;
   logic [NSLOT-1:0]      gnt;
   logic [IDX_W-1:0]      sel_idx;
   logic                  buf_eob;
   logic                  have_pair;
   logic                  on_final;
   logic                  take_col;
   logic                  take_pair;
   cxd_pair_t             sel_pair;

   for (genvar s = 0; s < NSLOT; s++) begin : g_unpack
      assign in_pairs[s].ctx = col_ctx[s*CTX_W +: CTX_W];
      assign in_pairs[s].dec = col_dec[s];
   end

   assign col_ready = (pend == '0);
   assign take_col  = col_valid && col_ready;
   assign take_pair = pair_valid && pair_ready;

   cxd_slot_buf #(.NSLOT(NSLOT)) i_buf (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (take_col),
      .load_mask  (col_slot_vld),
      .load_pairs (in_pairs),
      .load_eob   (col_eob),
      .drop       (take_pair),
      .drop_sel   (gnt),
      .pend       (pend),
      .pairs      (buf_pairs),
      .eob        (buf_eob)
   );

   cxd_pick #(.NSLOT(NSLOT), .STYLE(PICK)) i_pick (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (pend),
      .gnt       (gnt),
      .idx       (sel_idx),
      .any       (have_pair),
      .final_one (on_final)
   );

   assign sel_pair   = buf_pairs[sel_idx];
   assign pair_valid = have_pair;
   assign pair_ctx   = sel_pair.ctx;
   assign pair_dec   = sel_pair.dec;
   assign pair_eob   = buf_eob && on_final;

   // R5
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pair_valid && !pair_ready |=> pair_valid && $stable(pair_ctx)
                                    && $stable(pair_dec) && $stable(pair_eob));

   // R4
   busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pair_valid |-> !col_ready);

   // R8
   first_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_col && (col_slot_vld != '0) |=> pair_valid);

   // R7
   empty_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_col && (col_slot_vld == '0) |=> col_ready && !pair_valid);

   // R6
   eob_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pair_eob |-> pair_valid && ($countones(pend) == 1));

endmodule

// File: tb/test_cxd_sequencer.sv
module test_cxd_sequencer;
   localparam int NS = 10;
   localparam int CW = 5;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              col_valid;
   logic              col_ready;
   logic [NS-1:0]     col_slot_vld;
   logic [NS*CW-1:0]  col_ctx;
   logic [NS-1:0]     col_dec;
   logic              col_eob;
   logic              pair_valid;
   logic              pair_ready;
   logic [CW-1:0]     pair_ctx;
   logic              pair_dec;
   logic              pair_eob;

   int n_run  = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   cxd_sequencer #(.NSLOT(NS)) i_cxd_sequencer (
      .clk          (clk),
      .rst_n        (rst_n),
      .col_valid    (col_valid),
      .col_ready    (col_ready),
      .col_slot_vld (col_slot_vld),
      .col_ctx      (col_ctx),
      .col_dec      (col_dec),
      .col_eob      (col_eob),
      .pair_valid   (pair_valid),
      .pair_ready   (pair_ready),
      .pair_ctx     (pair_ctx),
      .pair_dec     (pair_dec),
      .pair_eob     (pair_eob)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [CW-1:0] ctx_of(input int seed, input int i);
      return CW'((seed * 7 + i * 11 + 3) % 32);
   endfunction

   function automatic logic dec_of(input int seed, input int i);
      return 1'((seed ^ i) & 1);
   endfunction

   task automatic fill(input int seed);
      for (int i = 0; i < NS; i++) begin
         col_ctx[i*CW +: CW] = ctx_of(seed, i);
         col_dec[i]          = dec_of(seed, i);
      end
   endtask

   // one burst: present, drain under a stall pattern, compare against ascending slot order
   task automatic run_burst(input logic [NS-1:0] vld, input int seed, input bit eob,
                            input logic [7:0] stall, input bit garbage);
      int    exp_idx[NS];
      int    n = 0;
      int    k = 0;
      int    c = 0;
      bit    rdy;
      bit    prev_stall = 0;
      string lbl;
      for (int i = 0; i < NS; i++) if (vld[i]) begin exp_idx[n] = i; n++; end
      @(negedge clk);
      check(col_ready == 1'b1, "R4 ready before burst", int'(col_ready), 1);
      col_valid    = 1'b1;
      col_slot_vld = vld;
      col_eob      = eob;
      fill(seed);
      @(negedge clk);
      col_valid = garbage;
      if (garbage) begin
         col_slot_vld = ~vld;
         col_eob      = ~eob;
         fill(seed + 99);
      end
      if (n == 0) begin
         check(pair_valid == 1'b0, "R7 empty burst no pair", int'(pair_valid), 0);
         check(col_ready == 1'b1, "R7 empty burst ready", int'(col_ready), 1);
         col_valid = 1'b0;
         return;
      end
      check(pair_valid == 1'b1, "R8 first pair next cycle", int'(pair_valid), 1);
      while (k < n && c < 400) begin
         rdy        = stall[c % 8];
         pair_ready = rdy;
         lbl = garbage ? "R9" : (prev_stall ? "R5" : "R2");
         check(pair_valid == 1'b1, "R3 no bubble", int'(pair_valid), 1);
         check(pair_ctx == ctx_of(seed, exp_idx[k]), {lbl, " ctx"}, int'(pair_ctx),
               int'(ctx_of(seed, exp_idx[k])));
         check(pair_dec == dec_of(seed, exp_idx[k]), {lbl, " dec"}, int'(pair_dec),
               int'(dec_of(seed, exp_idx[k])));
         check(pair_eob == (eob && k == n - 1), "R6 eob", int'(pair_eob),
               int'(eob && k == n - 1));
         check(col_ready == 1'b0, "R4 busy", int'(col_ready), 0);
         if (garbage && rdy && k == n - 1) col_valid = 1'b0;
         @(negedge clk);
         if (rdy) k++;
         prev_stall = !rdy;
         c++;
      end
      pair_ready = 1'b0;
      col_valid  = 1'b0;
      check(pair_valid == 1'b0, garbage ? "R9 no extra pair" : "R2 no extra pair",
            int'(pair_valid), 0);
      check(col_ready == 1'b1, "R4 ready after drain", int'(col_ready), 1);
   endtask

   task automatic t_reset();
      rst_n = 1'b0; col_valid = 1'b0; col_slot_vld = '0; col_ctx = '0;
      col_dec = '0; col_eob = 1'b0; pair_ready = 1'b0;
      repeat (3) @(negedge clk);
      check(pair_valid == 1'b0, "R1 valid in reset", int'(pair_valid), 0);
      check(col_ready == 1'b1, "R1 ready in reset", int'(col_ready), 1);
      rst_n = 1'b1;
      @(negedge clk);
      check(pair_valid == 1'b0, "R1 valid after reset", int'(pair_valid), 0);
      check(col_ready == 1'b1, "R1 ready after reset", int'(col_ready), 1);
   endtask

   task automatic t_full();       run_burst(10'h3FF, 1, 1'b0, 8'hFF, 1'b0); endtask
   task automatic t_sparse();     run_burst(10'b1000110101, 2, 1'b1, 8'hFF, 1'b0); endtask
   task automatic t_stall();      run_burst(10'b0111011110, 3, 1'b1, 8'b10010110, 1'b0); endtask
   task automatic t_empty();      run_burst(10'h000, 4, 1'b1, 8'hFF, 1'b0); endtask
   task automatic t_garbage();    run_burst(10'b0101010011, 5, 1'b0, 8'b01101101, 1'b1); endtask
   task automatic t_single_eob(); run_burst(10'b1000000000, 6, 1'b1, 8'b00110011, 1'b0); endtask
   task automatic t_back2back();
      run_burst(10'b0000001111, 7, 1'b0, 8'hFF, 1'b0);
      run_burst(10'b1111000000, 8, 1'b1, 8'b11011011, 1'b0);
   endtask

   initial begin
      t_reset();
      t_full();
      t_sparse();
      t_stall();
      t_empty();
      t_garbage();
      t_single_eob();
      t_back2back();
      t_full();
      repeat (2) @(negedge clk);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #2000000;
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule